// File: doc/BRIEF.md
# Half-Integer and Fractional M/N Clock-Enable Generator

This block derives a slower clock from a source clock without creating a new clock domain. It produces a one-cycle enable pulse train whose average rate is the source rate scaled first by a half-integer pre-divider and then by an M/N fraction. It also produces an output level whose high-time within each output period is programmable, giving a roughly square waveform when the fractional stage is in dual-edge mode. Downstream logic either gates its registers with the enable or uses the level as a divided clock reference.

Configuration arrives as already-committed field values. The pre-divider field h gives a division by (h+1)/2, and zero means bypass. The mode field turns the fractional stage on. M is given directly. The N and D fields arrive bitwise-inverted. N carries the inverse of n − m, so the block rebuilds n itself. A new configuration is copied into the working copy only when an output pulse ends a period. An output period is therefore never cut short.

Internally, a two-flop synchronizer releases reset synchronously. A half-cycle accumulator forms the pre-divided event stream. A modulo-n accumulator forms the fractional stage and the high-time counter.

Top module: `frac_clk_gen`

## Requirements
- R1: While rst_n is low, out_en and out_clk are 0. After rst_n rises, the configuration in use is all-zero (bypass), and the first out_en pulse appears in the third clock cycle.
- R2: With pre-divider field h = 0, a pre-divider event occurs every source cycle. With h ≠ 0, exactly 2 events occur per h+1 source cycles, from a half-cycle accumulator that adds 2 each cycle and fires when it reaches h+1.
- R3: The fractional modulus is rebuilt as n = (bitwise inverse of the N field, masked to the M/N width) + m. The high-time is decoded as the bitwise inverse of the D field, masked the same way.
- R4: When mode ≠ 0 and 0 < m < n, an accumulator adds m on each pre-divider event and wraps modulo n. out_en pulses one cycle after each wrap, giving exactly m pulses per n pre-divider events. There is never a pulse without a pre-divider event.
- R5: When mode = 0, or m = 0, or m ≥ n, the fractional stage is a pass-through. out_en then follows every pre-divider event.
- R6: out_clk rises with each out_en pulse and stays high until the decoded high-time d has elapsed, measured in pre-divider events after the pulse. d is clamped to the range 1..n−1. In pass-through, d is 1.
- R7: Input configuration is adopted only in the cycle out_en is high. If it differs from the working copy, both accumulators restart from zero. The period in progress always completes with the old values.
- R8: Over a long window, the out_en count equals W·2·m / ((h+1)·n) within ±2 pulses, where the factor 2/(h+1) is replaced by 1 when h = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prediv | input | PD_W | Pre-divider field h (0 = bypass) |
| cfg_mode | input | 2 | Fractional mode (nonzero enables M/N; 2 = dual-edge) |
| cfg_m | input | MN_W | Numerator m |
| cfg_ninv | input | MN_W | Inverse of (n − m) |
| cfg_dinv | input | MN_W | Inverse of the high-time d |
| out_en | output | 1 | One-cycle output clock enable |
| out_clk | output | 1 | Divided output level |

## Verification
Suppose the half-cycle or modulo-n accumulator holds a wrong residue. The out_en pulse then lands one or more cycles early or late within the same output period, and a cycle-exact reference model catches this at that pulse. A wrong decoded n or pre-divider ratio shows as a drift in pulse count that grows with the window length. Long-window rate checks catch this even when individual gaps look plausible. A high-time counter that is loaded or decremented wrongly shows as an out_clk edge displaced in the first period after the pulse. A configuration adopted mid-period shows as a shortened gap to the next pulse, right after the change.

// File: rtl/frac_clk_pkg.sv
package frac_clk_pkg;
  // width of the fractional mode field
  localparam int MODE_W = 2;
  // mode value that the driver programs for an m != n ratio
  localparam logic [MODE_W-1:0] MODE_DUAL_EDGE = 2'd2;
  // half-cycle units added per source cycle in the pre-divider
  localparam int HALF_STEP = 2;
endpackage

// File: rtl/frac_rst_sync.sv
module frac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_core_n = stage2_q;
endmodule

// File: rtl/frac_predivider.sv
module frac_predivider
  import frac_clk_pkg::*;
#(
  parameter int PD_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PD_W-1:0] div_i,
  input  logic            restart_i,
  output logic            fire_o
);
  localparam int AW = PD_W + 2;

  logic [AW-1:0] acc_q, acc_d;
  logic [AW-1:0] sum, lim;
  logic          bypass;

  always_comb begin
    bypass = (div_i == '0);
    lim    = {2'b00, div_i} + AW'(1);
    sum    = acc_q + AW'(HALF_STEP);
    fire_o = bypass || (sum >= lim);
    if (restart_i || bypass) acc_d = '0;
    else if (fire_o)         acc_d = sum - lim;
    else                     acc_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  AST_PREDIV_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass) |-> (acc_q < lim)); // R2
  AST_BYPASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && $past(bypass)) |-> (acc_q == '0)); // R2
endmodule

// File: rtl/frac_mn_stage.sv
module frac_mn_stage
  import frac_clk_pkg::*;
#(
  parameter int MN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_fire_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [MN_W-1:0]   m_i,
  input  logic [MN_W-1:0]   ninv_i,
  input  logic [MN_W-1:0]   dinv_i,
  input  logic              restart_i,
  output logic              fire_o,
  output logic              en_o,
  output logic              clk_o
);
  localparam int NW = MN_W + 1;
  localparam int SW = MN_W + 2;

  logic [NW-1:0] n_dec, nm1, d_dec, high_len;
  logic [NW-1:0] acc_q, acc_d;
  logic [SW-1:0] sum;
  logic [NW-1:0] hcnt_q, hcnt_d;
  logic          en_q;
  logic          mn_on;

  // modulus and high-time decode
  always_comb begin
    n_dec = {1'b0, ~ninv_i} + {1'b0, m_i};
    nm1   = n_dec - NW'(1);
    d_dec = {1'b0, ~dinv_i};
    mn_on = (mode_i != '0) && (m_i != '0) && ({1'b0, m_i} < n_dec);
    if (!mn_on)            high_len = NW'(1);
    else if (d_dec == '0)  high_len = NW'(1);
    else if (d_dec > nm1)  high_len = nm1;
    else                   high_len = d_dec;
  end

  // modulo-n accumulator
  always_comb begin
    sum    = {1'b0, acc_q} + {2'b00, m_i};
    fire_o = 1'b0;
    acc_d  = acc_q;
    if (!mn_on) begin
      fire_o = pre_fire_i;
      acc_d  = '0;
    end else if (pre_fire_i) begin
      fire_o = (sum >= {1'b0, n_dec});
      acc_d  = fire_o ? NW'(sum - {1'b0, n_dec}) : NW'(sum);
    end
    if (restart_i) acc_d = '0;
  end

  // high-time counter
  always_comb begin
    hcnt_d = hcnt_q;
    if (fire_o)                            hcnt_d = high_len;
    else if (pre_fire_i && hcnt_q != '0)   hcnt_d = hcnt_q - NW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      hcnt_q <= '0;
      en_q   <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      hcnt_q <= hcnt_d;
      en_q   <= fire_o;
    end
  end

  assign en_o  = en_q;
  assign clk_o = (hcnt_q != '0);

  AST_MN_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
    mn_on |-> (acc_q < n_dec)); // R4
  AST_PULSE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |-> $past(pre_fire_i)); // R4
  AST_HIGH_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |-> clk_o); // R6
  AST_LOW_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_o) |-> $past(pre_fire_i)); // R6
endmodule

// File: rtl/frac_clk_gen.sv
module frac_clk_gen
  import frac_clk_pkg::*;
#(
  parameter int PD_W = 5,
  parameter int MN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PD_W-1:0]   cfg_prediv,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [MN_W-1:0]   cfg_m,
  input  logic [MN_W-1:0]   cfg_ninv,
  input  logic [MN_W-1:0]   cfg_dinv,
  output logic              out_en,
  output logic              out_clk
);
  localparam int CW = PD_W + MODE_W + 3 * MN_W;

  logic          rst_core_n;
  logic [CW-1:0] cfg_in, act_q, act_d;
  logic          pre_fire, mn_fire, restart;
  logic [PD_W-1:0]   act_div;
  logic [MODE_W-1:0] act_mode;
  logic [MN_W-1:0]   act_m, act_ninv, act_dinv;

  frac_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  // working copy, refreshed only at a period boundary
  always_comb begin
    cfg_in  = {cfg_prediv, cfg_mode, cfg_m, cfg_ninv, cfg_dinv};
    restart = mn_fire && (cfg_in != act_q);
    act_d   = mn_fire ? cfg_in : act_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) act_q <= '0;
    else             act_q <= act_d;
  end

  assign {act_div, act_mode, act_m, act_ninv, act_dinv} = act_q;

  frac_predivider #(.PD_W(PD_W)) i_predivider (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .div_i     (act_div),
    .restart_i (restart),
    .fire_o    (pre_fire)
  );

  frac_mn_stage #(.MN_W(MN_W)) i_mn_stage (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .pre_fire_i (pre_fire),
    .mode_i     (act_mode),
    .m_i        (act_m),
    .ninv_i     (act_ninv),
    .dinv_i     (act_dinv),
    .restart_i  (restart),
    .fire_o     (mn_fire),
    .en_o       (out_en),
    .clk_o      (out_clk)
  );

  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!$stable(act_q)) |-> out_en); // R7
  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    (!rst_n) |-> (!out_en && !out_clk)); // R1
endmodule

// File: tb/test_frac_clk_gen.sv
module test_frac_clk_gen;
  localparam int CLK_PERIOD = 10;
  localparam int PD_W = 5;
  localparam int MN_W = 8;
  localparam int MASK = (1 << MN_W) - 1;
  localparam int WIN  = 2160;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [PD_W-1:0]  cfg_prediv = '0;
  logic [1:0]       cfg_mode = '0;
  logic [MN_W-1:0]  cfg_m = '0, cfg_ninv = '0, cfg_dinv = '0;
  logic             out_en, out_clk;

  int checks = 0, failures = 0, cyc = 0;
  bit cmp_on = 0;
  string cur_tag = "R1";

  frac_clk_gen #(.PD_W(PD_W), .MN_W(MN_W)) i_frac_clk_gen (
    .clk(clk), .rst_n(rst_n), .cfg_prediv(cfg_prediv), .cfg_mode(cfg_mode),
    .cfg_m(cfg_m), .cfg_ninv(cfg_ninv), .cfg_dinv(cfg_dinv),
    .out_en(out_en), .out_clk(out_clk));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int s1 = 0, s2 = 0, old_s2;
  int a_div = 0, a_mode = 0, a_m = 0, a_ninv = 0, a_dinv = 0;
  int halves = 0, phase = 0, hi_left = 0;
  int nn, dd, dh, sm, nxt_half, nxt_phase;
  bit pf, fr, mn, diff;
  bit exp_en = 0, exp_clk = 0;

  always @(posedge clk) begin
    old_s2 = s2;
    if (!rst_n) begin s1 = 0; s2 = 0; end
    else begin s2 = s1; s1 = 1; end
    if (!rst_n || old_s2 == 0) begin
      a_div = 0; a_mode = 0; a_m = 0; a_ninv = 0; a_dinv = 0;
      halves = 0; phase = 0; hi_left = 0; exp_en = 0; exp_clk = 0;
    end else begin
      pf = (a_div == 0) || (halves + 2 >= a_div + 1);
      if (a_div == 0) nxt_half = 0;
      else if (pf)    nxt_half = halves + 2 - (a_div + 1);
      else            nxt_half = halves + 2;
      nn = ((~a_ninv) & MASK) + a_m;
      mn = (a_mode != 0) && (a_m != 0) && (a_m < nn);
      if (!mn) begin fr = pf; nxt_phase = 0; end
      else if (pf) begin
        sm = phase + a_m; fr = (sm >= nn); nxt_phase = fr ? sm - nn : sm;
      end else begin fr = 0; nxt_phase = phase; end
      dd = (~a_dinv) & MASK;
      if (!mn) dh = 1;
      else if (dd == 0) dh = 1;
      else if (dd > nn - 1) dh = nn - 1;
      else dh = dd;
      if (fr) hi_left = dh;
      else if (pf && hi_left > 0) hi_left = hi_left - 1;
      halves = nxt_half; phase = nxt_phase;
      if (fr) begin
        diff = (a_div != int'(cfg_prediv)) || (a_mode != int'(cfg_mode)) ||
               (a_m != int'(cfg_m)) || (a_ninv != int'(cfg_ninv)) || (a_dinv != int'(cfg_dinv));
        a_div = cfg_prediv; a_mode = cfg_mode; a_m = cfg_m;
        a_ninv = cfg_ninv; a_dinv = cfg_dinv;
        if (diff) begin halves = 0; phase = 0; end
      end
      exp_en = fr; exp_clk = (hi_left != 0);
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (out_en !== exp_en || out_clk !== exp_clk) begin
        failures++;
        $display("FAIL %s cycle %0d: en/clk actual=%b%b expected=%b%b",
                 cur_tag, cyc, out_en, out_clk, exp_en, exp_clk);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: cycles actual=%0d expected<=150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic set_cfg(input int h, input int mode, input int m, input int n, input int d);
    cfg_prediv = PD_W'(h);
    cfg_mode   = 2'(mode);
    cfg_m      = MN_W'(m);
    cfg_ninv   = MN_W'((~(n - m)) & MASK);
    cfg_dinv   = MN_W'((~d) & MASK);
  endtask

  task automatic wait_pulse(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!out_en && gap < 5000);
  endtask

  task automatic settle_and_measure(input string tag, input int expv);
    int g, cnt;
    wait_pulse(g); wait_pulse(g); wait_pulse(g);
    cnt = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (out_en) cnt++;
    end
    check((cnt >= expv - 2) && (cnt <= expv + 2), tag, cnt, expv);
  endtask

  initial begin
    int g;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(out_en == 0 && out_clk == 0, "R1 reset outputs", {out_en, out_clk}, 0);
    rst_n = 1'b1;
    cmp_on = 1;
    wait_pulse(g);
    check(g == 3, "R1 first pulse after release", g, 3);

    // R2 / R5: full bypass, every cycle
    cur_tag = "R2";
    settle_and_measure("R2 bypass rate", WIN);
    // R2: divide by 2 (h=3) and by 2.5 (h=4)
    set_cfg(3, 0, 0, 1, 0);
    settle_and_measure("R2 h=3 rate", WIN / 2);
    set_cfg(4, 0, 0, 1, 0);
    settle_and_measure("R2 h=4 rate", WIN * 2 / 5);

    // R3 / R4 / R6 / R8: m=3 n=8 d=4, no pre-division
    cur_tag = "R4";
    set_cfg(0, 2, 3, 8, 4);
    settle_and_measure("R4 R8 m3 n8 rate", WIN * 3 / 8);
    // R3 / R8: m=2 n=9 with divide by 1.5
    cur_tag = "R3";
    set_cfg(2, 2, 2, 9, 3);
    settle_and_measure("R3 R8 m2 n9 h2 rate", WIN * 2 * 2 / (3 * 9));

    // R5: m equal to n and m zero both pass through
    cur_tag = "R5";
    set_cfg(0, 2, 7, 7, 3);
    settle_and_measure("R5 m==n pass", WIN);
    set_cfg(3, 2, 0, 9, 3);
    settle_and_measure("R5 m==0 pass", WIN / 2);

    // R6: high-time clamps (d=0 -> 1, d=20 -> n-1=7)
    cur_tag = "R6";
    set_cfg(0, 2, 1, 8, 0);
    settle_and_measure("R6 d=0 clamp rate", WIN / 8);
    set_cfg(0, 2, 1, 8, 20);
    settle_and_measure("R6 d>n-1 clamp rate", WIN / 8);

    // R7: change mid-period, old period must finish
    cur_tag = "R7";
    set_cfg(0, 2, 1, 40, 10);
    wait_pulse(g); wait_pulse(g); wait_pulse(g);
    repeat (5) @(negedge clk);
    set_cfg(0, 0, 0, 1, 0);
    wait_pulse(g);
    check(g == 35, "R7 old period completes", g, 35);
    wait_pulse(g);
    check(g == 1, "R7 new config after boundary", g, 1);

    cmp_on = 0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule